// File: doc/BRIEF.md
# Timed Unlock Guard for Configuration Bits

This block protects a field of critical configuration bits inside one register against stray writes from software that has lost control. Software unlocks the field by writing the key byte 0xAA and then the key byte 0x55 to a dedicated unlock register at address 0xC7. Each step must fall inside a short budget counted in instruction cycles. The protected register sits at address 0x8E. Its unguarded bits accept any write. Its guarded bits change only through a write made while the unlock window is open.

Two down-counters are loaded together when the first key byte is accepted. The arm counter, loaded with 2, bounds the wait for the second key byte. The window counter, loaded with 4, bounds the whole attempt, including the guarded write. Both counters move only on the instruction-cycle tick input. A new attempt cannot start while the window counter is still running. A stray or repeated key write therefore cannot stretch or restart an attempt that has failed.

Top module: `tacc_guard`

## Requirements
- R1: A synchronous active-high reset sets `cfg_q` to 0x00, clears both counters and makes `win_open` and `prot_wen` 0. A 0x55 written right after reset does not open the window. A full 0xAA, 0x55 sequence written right after reset does open it.
- R2: A write of 0xAA to address 0xC7, followed by a write of 0x55 to 0xC7, makes `win_open` read 1 in the cycle after the 0x55 write.
- R3: The 0x55 write is accepted only while fewer than 2 ticks have passed since the 0xAA write. A tick in the cycle of the 0x55 write itself does not count against it. On the second tick with no 0x55, the block locks, and a later 0x55 opens nothing.
- R4: The window closes on the fourth tick after the 0xAA write. `win_open` drops then, and a later write to 0x8E leaves the guarded bits unchanged. A guarded write made in the cycle before that tick is still accepted.
- R5: A 0xAA written to 0xC7 while the window counter from an earlier attempt still runs starts nothing. A following 0x55 opens nothing, and a later write to 0x8E leaves the guarded bits unchanged.
- R6: A write to 0xC7 of any value other than the one expected in the current state locks the block at once. This includes a wrong second byte, and any key write while the window is open.
- R7: A write to 0x8E while the window is open loads all 8 bits, closes the window, and clears the window counter. It also raises `prot_wen` for exactly one cycle, in the cycle after the write. Only one guarded write is allowed per unlock.
- R8: The guarded bits are bits 7:4 (mask 0xF0). A write to 0x8E while the window is closed updates bits 3:0 and leaves bits 7:4 unchanged.
- R9: Neither counter advances in a cycle with `tick` low. With no ticks, an armed or open attempt waits indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle tick; advances both counters |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| cfg_q | output | 8 | Contents of the configuration register |
| prot_wen | output | 1 | One-cycle pulse after a guarded write is committed |
| win_open | output | 1 | Guarded-write window currently open |

## Verification
On every cycle, the assertions check the following:
- the window opens only right after a 0x55 key write;
- a key write while the window is open always closes it;
- a commit pulse never coincides with an open window;
- the guarded bits never move while the window is closed;
- nothing changes in a cycle with neither a tick nor a write.

The exact tick budgets can only be shown by the bench's scenarios, because they depend on the history of earlier attempts. These cases are the late-but-legal second key byte, the last-cycle guarded write, the refusal of a new attempt while an old window is still counting, and the recovery after reset.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_ARM  = 2'd1,
    ST_OPEN = 2'd2
  } tacc_st_e;

  // keep masked bits from old, take the rest from new
  function automatic logic [7:0] keep_masked(input logic [7:0] old_v,
                                             input logic [7:0] new_v,
                                             input logic [7:0] mask);
    return (old_v & mask) | (new_v & ~mask);
  endfunction

endpackage

// File: rtl/tacc_cdown.sv
module tacc_cdown #(
  parameter int W        = 3,
  parameter int LOAD_VAL = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         last
);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (load)              cnt <= W'(LOAD_VAL);
    else if (tick && cnt != '0) cnt <= cnt - W'(1);
  end

  // counter reaches zero at this edge
  assign last = tick && !load && !clr && (cnt == W'(1));

endmodule

// File: rtl/tacc_seq.sv
module tacc_seq
  import tacc_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  KEY1    = 8'hAA,
  parameter logic [7:0]  KEY2    = 8'h55,
  parameter int          ARM_CYC = 2,
  parameter int          WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              cfg_wr,
  output logic              commit,
  output logic              win_open
);

  localparam int ARM_W = $clog2(ARM_CYC + 1);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  tacc_st_e   st, st_nx;
  logic [ARM_W-1:0] arm_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic arm_last, win_last;
  logic start, arm_ok;

  assign start  = key_wr && (key_data == DATA_W'(KEY1)) && (win_cnt == '0);
  assign arm_ok = (st == ST_ARM) && key_wr && (key_data == DATA_W'(KEY2));
  assign commit = (st == ST_OPEN) && cfg_wr;

  tacc_cdown #(.W(ARM_W), .LOAD_VAL(ARM_CYC)) u_arm (
    .clk(clk), .rst(rst), .tick(tick), .load(start), .clr(1'b0),
    .cnt(arm_cnt), .last(arm_last)
  );

  tacc_cdown #(.W(WIN_W), .LOAD_VAL(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .tick(tick), .load(start), .clr(commit),
    .cnt(win_cnt), .last(win_last)
  );

  always_comb begin
    st_nx = st;
    if (start) begin
      st_nx = ST_ARM;
    end else begin
      unique case (st)
        ST_ARM: begin
          if (arm_ok)                      st_nx = ST_OPEN;
          else if (key_wr)                 st_nx = ST_LOCK;
          else if (arm_last || win_last)   st_nx = ST_LOCK;
        end
        ST_OPEN: begin
          if (commit)                      st_nx = ST_LOCK;
          else if (key_wr || win_last)     st_nx = ST_LOCK;
        end
        default:                           st_nx = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_LOCK;
    else     st <= st_nx;
  end

  assign win_open = (st == ST_OPEN);

endmodule

// File: rtl/tacc_cfgreg.sv
module tacc_cfgreg
  import tacc_pkg::*;
#(
  parameter logic [7:0] PROT_MASK = 8'hF0,
  parameter logic [7:0] RST_VAL   = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       commit,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RST_VAL;
      pulse <= 1'b0;
    end else begin
      pulse <= commit;
      if (commit)  q <= wdata;
      else if (wr) q <= keep_masked(q, wdata, PROT_MASK);
    end
  end

endmodule

// File: rtl/tacc_guard.sv
module tacc_guard #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] KEY_ADDR  = 8'hC7,
  parameter logic [7:0] CFG_ADDR  = 8'h8E,
  parameter logic [7:0] KEY1      = 8'hAA,
  parameter logic [7:0] KEY2      = 8'h55,
  parameter int         ARM_CYC   = 2,
  parameter int         WIN_CYC   = 4,
  parameter logic [7:0] PROT_MASK = 8'hF0,
  parameter logic [7:0] RST_VAL   = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        cfg_q,
  output logic              prot_wen,
  output logic              win_open
);

  logic key_wr, cfg_wr, commit;

  assign key_wr = sfr_we && (sfr_addr == ADDR_W'(KEY_ADDR));
  assign cfg_wr = sfr_we && (sfr_addr == ADDR_W'(CFG_ADDR));

  tacc_seq #(
    .DATA_W(8), .KEY1(KEY1), .KEY2(KEY2),
    .ARM_CYC(ARM_CYC), .WIN_CYC(WIN_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .key_wr(key_wr), .key_data(sfr_wdata), .cfg_wr(cfg_wr),
    .commit(commit), .win_open(win_open)
  );

  tacc_cfgreg #(.PROT_MASK(PROT_MASK), .RST_VAL(RST_VAL)) u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .commit(commit),
    .wdata(sfr_wdata), .q(cfg_q), .pulse(prot_wen)
  );

endmodule

// File: rtl/tacc_guard_chk.sv
module tacc_guard_chk #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] KEY_ADDR  = 8'hC7,
  parameter logic [7:0] KEY2      = 8'h55,
  parameter logic [7:0] PROT_MASK = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        cfg_q,
  input logic              prot_wen,
  input logic              win_open
);

  logic key_w;
  assign key_w = sfr_we && (sfr_addr == ADDR_W'(KEY_ADDR));

  // R2
  open_after_key2_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(win_open)) |-> $past(key_w && sfr_wdata == KEY2));

  // R6
  key_write_locks_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(win_open && key_w)) |-> !win_open);

  // R7
  commit_closes_chk: assert property (@(posedge clk) disable iff (rst)
    prot_wen |-> !win_open);

  // R8
  guarded_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(win_open)) |-> ((cfg_q & PROT_MASK) == ($past(cfg_q) & PROT_MASK)));

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!tick && !sfr_we)) |-> ($stable(win_open) && $stable(cfg_q)));

endmodule

bind tacc_guard tacc_guard_chk #(
  .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .KEY2(KEY2), .PROT_MASK(PROT_MASK)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .cfg_q(cfg_q), .prot_wen(prot_wen), .win_open(win_open)
);

// File: tb/sim_tacc_guard.sv
`timescale 1ns/1ps
module sim_tacc_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] cfg_q;
  logic       prot_wen, win_open;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tacc_guard u0 (
    .clk(clk), .rst(rst), .tick(tick), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .cfg_q(cfg_q), .prot_wen(prot_wen), .win_open(win_open)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
    logic       tk;
    logic [7:0] ecfg;
    logic       eopen;
    logic       epw;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 46;
  // R2 unlock, R3 second-byte budget, R4 window bound, R5 refusal,
  // R6 wrong key locks, R7 single commit, R8 mask, R9 tick gating
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h8E, 8'hFF, 1'b1, 8'h0F, 1'b0, 1'b0, 4'd8},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'h0F, 1'b0, 1'b0, 4'd2},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h0F, 1'b1, 1'b0, 4'd2},
    '{1'b1, 8'h8E, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b1, 4'd7},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hA5, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b0, 4'd3},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'hA5, 1'b1, 1'b0, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b0, 4'd4},
    '{1'b1, 8'h8E, 8'h3C, 1'b1, 8'hAC, 1'b0, 1'b0, 4'd8},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hAC, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hAC, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hAC, 1'b0, 1'b0, 4'd3},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'hAC, 1'b0, 1'b0, 4'd3},
    '{1'b1, 8'h8E, 8'hFF, 1'b1, 8'hAF, 1'b0, 1'b0, 4'd8},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hAF, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'hC7, 8'h12, 1'b1, 8'hAF, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hAF, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'hAF, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'h8E, 8'h00, 1'b1, 8'hA0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hA0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'hA0, 1'b1, 1'b0, 4'd2},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hA0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'h8E, 8'h5A, 1'b1, 8'hAA, 1'b0, 1'b0, 4'd6},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hAA, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'hAA, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'hAA, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'hAA, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'hAA, 1'b0, 1'b0, 4'd9},
    '{1'b1, 8'hC7, 8'h55, 1'b0, 8'hAA, 1'b1, 1'b0, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'hAA, 1'b1, 1'b0, 4'd9},
    '{1'b1, 8'h8E, 8'h33, 1'b0, 8'h33, 1'b0, 1'b1, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h33, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'h33, 1'b0, 1'b0, 4'd4},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h33, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h33, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h33, 1'b1, 1'b0, 4'd4},
    '{1'b1, 8'h8E, 8'hF0, 1'b1, 8'hF0, 1'b0, 1'b1, 4'd4},
    '{1'b1, 8'h8E, 8'h0F, 1'b1, 8'hFF, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'hC7, 8'hAA, 1'b1, 8'hFF, 1'b0, 1'b0, 4'd4},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'hFF, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 4'd4},
    '{1'b1, 8'h8E, 8'h05, 1'b1, 8'hF5, 1'b0, 1'b0, 4'd4}
  };

  task automatic check(input string what, input int req, input logic [7:0] ecfg,
                       input logic eopen, input logic epw);
    checks++;
    if (cfg_q !== ecfg || win_open !== eopen || prot_wen !== epw) begin
      errors++;
      $display("FAIL R%0d %s: cfg=%h open=%b pw=%b expected cfg=%h open=%b pw=%b",
               req, what, cfg_q, win_open, prot_wen, ecfg, eopen, epw);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic tk);
    @(negedge clk);
    sfr_we = we; sfr_addr = a; sfr_wdata = d; tick = tk;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("reset state", 1, 8'h00, 1'b0, 1'b0);   // R1

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].tk);
      check($sformatf("vector %0d", i), int'(VEC[i].req),
            VEC[i].ecfg, VEC[i].eopen, VEC[i].epw);
    end

    // R1: reset while the window is open
    step(1'b1, 8'hC7, 8'hAA, 1'b1);
    step(1'b1, 8'hC7, 8'h55, 1'b1);
    check("open before reset", 1, 8'hF5, 1'b1, 1'b0);
    @(negedge clk) rst = 1'b1; sfr_we = 1'b0; tick = 1'b1;
    @(posedge clk); #1;
    check("reset mid window", 1, 8'h00, 1'b0, 1'b0);
    @(negedge clk) rst = 1'b0;
    step(1'b1, 8'hC7, 8'h55, 1'b1);
    check("0x55 after reset opens nothing", 1, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'hC7, 8'hAA, 1'b1);
    step(1'b1, 8'hC7, 8'h55, 1'b1);
    check("counters cleared by reset", 1, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h8E, 8'hC3, 1'b1);
    check("commit after reset", 7, 8'hC3, 1'b0, 1'b1);
    step(1'b0, 8'h00, 8'h00, 1'b1);
    check("pulse lasts one cycle", 7, 8'hC3, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule